// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block brings up a parallel character display and keeps it busy without any help from software. It runs on one system clock (100 MHz by default) and makes its own one-cycle microsecond enable pulse from it. Every wait is counted in those microsecond pulses, so each delay parameter is written in microseconds.

After reset the block waits for the panel to power up. It then sends three commands: 8-bit two-line function set, display on, and clear. Next it writes a fixed line of text held in a parameter, one byte at a time. After the text it sends a shift-left command over and over, slowly enough that the text scrolls at a readable rate. A done flag goes high once the last character has been strobed. The bus is write-only: read/write stays low and the busy flag is never polled, so the fixed waits must cover the panel's worst-case command times.

Top module: `lcd_cmd_seq`

## Requirements
- R1: The microsecond tick is high for one clock cycle out of every CLK_PER_US cycles. It comes from a divider that counts from 0 up to CLK_PER_US-1 and then wraps.
- R2: After synchronous reset is released, the enable strobe first rises (DLY_POWER_US+1)*CLK_PER_US clock edges later: the power-up wait plus one setup tick.
- R3: The wait counter advances only on ticks and clears on the tick that reaches its terminal value. A wait of D microseconds therefore puts the rising edges of two successive strobes (D+2)*CLK_PER_US cycles apart. This applies to the DLY_CMD_US waits after function set and display control, and to the DLY_CLEAR_US wait after clear.
- R4: The first three bytes are sent with register select low, in this order: 0x38 (function set), 0x0C (display control), 0x01 (clear).
- R5: Next come NUM_CHARS data bytes with register select high, taken from LINE_TEXT with the most significant byte first. Each one is followed by a DLY_CHAR_US wait.
- R6: After the last character, the byte 0x18 (shift left) is sent with register select low, repeated forever, with a DLY_SHIFT_US wait after each one.
- R7: The enable strobe stays high for exactly CLK_PER_US cycles and rises only just after a tick. Data and register select are set one tick before it rises and do not change while it is high.
- R8: Read/write is always low.
- R9: The done flag stays low until the enable strobe of the last character falls. From then on it stays high until reset.
- R10: While reset is held high, the enable strobe, register select, data bus and done flag are all 0. After reset the sequence starts again from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lcd_data_o | output | 8 | Display data bus |
| lcd_rs_o | output | 1 | Register select: 0 = command, 1 = data |
| lcd_rw_o | output | 1 | Read/write, always 0 (write) |
| lcd_en_o | output | 1 | Enable strobe |
| text_done_o | output | 1 | High once the last character has been strobed |

## Verification
The hardest cases to reach are a reset arriving in the middle of a wait or strobe, and the change from the last character wait to the scroll wait, because at real parameter values both sit tens of milliseconds into a run. The bench shrinks the divider and every delay through parameters, so a full sequence lasts a few hundred cycles. It then applies resets at random points, seeded by $urandom, and checks each time that the sequence starts again from the power-up wait with the exact strobe spacing.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [2:0] {
    STEP_POWER, STEP_FSET, STEP_DCTL, STEP_CLEAR, STEP_CHAR, STEP_SHIFT
  } step_e;

  typedef enum logic [1:0] {PH_WAIT, PH_SETUP, PH_STROBE} phase_e;

  localparam logic [7:0] CMD_FUNC_SET  = 8'h38;
  localparam logic [7:0] CMD_DISP_CTRL = 8'h0C;
  localparam logic [7:0] CMD_CLEAR     = 8'h01;
  localparam logic [7:0] CMD_SHIFT_L   = 8'h18;

  // Byte of a command step; data steps get their byte elsewhere
  function automatic logic [7:0] cmd_byte(step_e s);
    case (s)
      STEP_FSET:  return CMD_FUNC_SET;
      STEP_DCTL:  return CMD_DISP_CTRL;
      STEP_CLEAR: return CMD_CLEAR;
      default:    return CMD_SHIFT_L;
    endcase
  endfunction
endpackage

// File: rtl/lcd_us_timebase.sv
module lcd_us_timebase #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = wrap;

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (wrap) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    div_q <= LAST); // R1
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (CLK_PER_US > 1) && tick_o |=> !tick_o); // R1
endmodule

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [CW-1:0] term_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step     = run_i && tick_i;
  assign expire_o = step && (cnt_q == term_i);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (step)     cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_i |-> cnt_q <= term_i); // R3
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> cnt_q == '0); // R3
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
  import lcd_seq_pkg::*;
#(
  parameter int NUM_CHARS    = 16,
  parameter logic [8*NUM_CHARS-1:0] LINE_TEXT = "SCROLLING TEXT  ",
  parameter int DLY_POWER_US = 20000,
  parameter int DLY_CMD_US   = 40,
  parameter int DLY_CLEAR_US = 1600,
  parameter int DLY_CHAR_US  = 2600,
  parameter int DLY_SHIFT_US = 250000,
  parameter int CW           = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          expire_i,
  output logic          run_o,
  output logic [CW-1:0] term_o,
  output logic [7:0]    data_o,
  output logic          rs_o,
  output logic          en_o,
  output logic          done_o
);
  localparam int IW = (NUM_CHARS > 1) ? $clog2(NUM_CHARS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CHARS - 1);

  step_e         step_q, nxt_step;
  phase_e        phase_q;
  logic [IW-1:0] idx_q, nxt_idx;
  logic [7:0]    data_q;
  logic          rs_q, done_q;
  logic          last_char, strobe_end;

  // Wait length in ticks for the byte just sent, minus one
  function automatic logic [CW-1:0] term_for(step_e s);
    case (s)
      STEP_POWER: return CW'(DLY_POWER_US - 1);
      STEP_FSET,
      STEP_DCTL:  return CW'(DLY_CMD_US - 1);
      STEP_CLEAR: return CW'(DLY_CLEAR_US - 1);
      STEP_CHAR:  return CW'(DLY_CHAR_US - 1);
      default:    return CW'(DLY_SHIFT_US - 1);
    endcase
  endfunction

  function automatic logic [7:0] char_at(logic [IW-1:0] i);
    return LINE_TEXT[8*(NUM_CHARS - 1 - int'(i)) +: 8];
  endfunction

  assign last_char  = (step_q == STEP_CHAR) && (idx_q == LAST_IDX);
  assign strobe_end = (phase_q == PH_STROBE) && tick_i;
  assign run_o      = (phase_q == PH_WAIT);
  assign term_o     = term_for(step_q);

  always_comb begin
    nxt_step = step_q;
    nxt_idx  = idx_q;
    case (step_q)
      STEP_POWER: nxt_step = STEP_FSET;
      STEP_FSET:  nxt_step = STEP_DCTL;
      STEP_DCTL:  nxt_step = STEP_CLEAR;
      STEP_CLEAR: begin nxt_step = STEP_CHAR; nxt_idx = '0; end
      STEP_CHAR: begin
        if (idx_q == LAST_IDX) nxt_step = STEP_SHIFT;
        else                   nxt_idx  = idx_q + 1'b1;
      end
      default:    nxt_step = STEP_SHIFT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= STEP_POWER;
      phase_q <= PH_WAIT;
      idx_q   <= '0;
      data_q  <= '0;
      rs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (phase_q)
        PH_WAIT: if (expire_i) begin
          step_q  <= nxt_step;
          idx_q   <= nxt_idx;
          phase_q <= PH_SETUP;
          rs_q    <= (nxt_step == STEP_CHAR);
          data_q  <= (nxt_step == STEP_CHAR) ? char_at(nxt_idx) : cmd_byte(nxt_step);
        end
        PH_SETUP: if (tick_i) phase_q <= PH_STROBE;
        default: if (strobe_end) begin
          phase_q <= PH_WAIT;
          if (last_char) done_q <= 1'b1;
        end
      endcase
    end
  end

  assign data_o = data_q;
  assign rs_o   = rs_q;
  assign en_o   = (phase_q == PH_STROBE);
  assign done_o = done_q;

  AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(en_o) |-> $past(tick_i)); // R7
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $stable(data_q) && $stable(rs_q)); // R7
  AST_SHIFT_IS_CMD: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_SHIFT) && en_o |-> !rs_q && data_q == CMD_SHIFT_L); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q); // R9
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq #(
  parameter int CLK_PER_US   = 100,
  parameter int NUM_CHARS    = 16,
  parameter logic [8*NUM_CHARS-1:0] LINE_TEXT = "SCROLLING TEXT  ",
  parameter int DLY_POWER_US = 20000,
  parameter int DLY_CMD_US   = 40,
  parameter int DLY_CLEAR_US = 1600,
  parameter int DLY_CHAR_US  = 2600,
  parameter int DLY_SHIFT_US = 250000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] lcd_data_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_en_o,
  output logic       text_done_o
);
  localparam int MAX_A  = (DLY_POWER_US > DLY_SHIFT_US) ? DLY_POWER_US : DLY_SHIFT_US;
  localparam int MAX_B  = (DLY_CLEAR_US > DLY_CHAR_US) ? DLY_CLEAR_US : DLY_CHAR_US;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D  = (MAX_AB > DLY_CMD_US) ? MAX_AB : DLY_CMD_US;
  localparam int CW     = $clog2(MAX_D + 1);

  logic          us_tick, wait_run, wait_expire;
  logic [CW-1:0] wait_term;

  lcd_us_timebase #(.CLK_PER_US(CLK_PER_US)) u_timebase (
    .clk(clk), .rst(rst), .tick_o(us_tick)
  );

  lcd_delay_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .tick_i(us_tick), .run_i(wait_run),
    .term_i(wait_term), .expire_o(wait_expire)
  );

  lcd_seq_fsm #(
    .NUM_CHARS(NUM_CHARS), .LINE_TEXT(LINE_TEXT),
    .DLY_POWER_US(DLY_POWER_US), .DLY_CMD_US(DLY_CMD_US),
    .DLY_CLEAR_US(DLY_CLEAR_US), .DLY_CHAR_US(DLY_CHAR_US),
    .DLY_SHIFT_US(DLY_SHIFT_US), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick_i(us_tick), .expire_i(wait_expire),
    .run_o(wait_run), .term_o(wait_term), .data_o(lcd_data_o),
    .rs_o(lcd_rs_o), .en_o(lcd_en_o), .done_o(text_done_o)
  );

  assign lcd_rw_o = 1'b0;
endmodule

// File: tb/test_lcd_cmd_seq.sv
module test_lcd_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 3;
  localparam int N    = 4;
  localparam logic [31:0] TXT = "WXYZ";
  localparam int DPWR = 20, DCMD = 4, DCLR = 9, DCHR = 6, DSHF = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] data;
  logic rs, rw, en, done;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_seq #(
    .CLK_PER_US(P), .NUM_CHARS(N), .LINE_TEXT(TXT),
    .DLY_POWER_US(DPWR), .DLY_CMD_US(DCMD), .DLY_CLEAR_US(DCLR),
    .DLY_CHAR_US(DCHR), .DLY_SHIFT_US(DSHF)
  ) i_lcd_cmd_seq (
    .clk(clk), .rst(rst), .lcd_data_o(data), .lcd_rs_o(rs),
    .lcd_rw_o(rw), .lcd_en_o(en), .text_done_o(done)
  );

  function automatic int exp_byte(int k);
    if (k == 0) return 8'h38;
    if (k == 1) return 8'h0C;
    if (k == 2) return 8'h01;
    if (k < 3 + N) return int'(TXT[8*(N-1-(k-3)) +: 8]);
    return 8'h18;
  endfunction

  function automatic int exp_rs(int k);
    return (k >= 3 && k < 3 + N) ? 1 : 0;
  endfunction

  function automatic int wait_after(int k);
    if (k < 2) return DCMD;
    if (k == 2) return DCLR;
    if (k < 3 + N) return DCHR;
    return DSHF;
  endfunction

  // Edges from reset release (or previous rise) to the next enable rise
  function automatic int exp_gap(int k);
    return (k == 0) ? (DPWR + 1) * P : (wait_after(k - 1) + 2) * P;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 en in reset", int'(en), 0);
    check("R10 rs in reset", int'(rs), 0);
    check("R10 data in reset", int'(data), 0);
    check("R10 done in reset", int'(done), 0);
    rst = 1'b0;
  endtask

  // Follows n strobes after a reset release made at the current negedge
  task automatic watch(int n);
    int cyc = 0, hi = 0, k = 0;
    logic prev_en = 1'b0;
    logic [7:0] held = '0;
    while (k < n) begin
      @(negedge clk);
      cyc++;
      check("R8 rw low", int'(rw), 0);
      if (en && !prev_en) begin
        check($sformatf("R2/R3 gap before byte %0d", k), cyc, exp_gap(k));
        check($sformatf("R4/R5/R6 byte %0d", k), int'(data), exp_byte(k));
        check($sformatf("R4/R5/R6 rs of byte %0d", k), int'(rs), exp_rs(k));
        check($sformatf("R9 done at byte %0d", k), int'(done), (k >= 3 + N) ? 1 : 0);
        held = data;
        cyc = 0;
        hi = 0;
        k++;
      end
      if (en) begin
        hi++;
        if (data != held) check("R7 data stable", int'(data), int'(held));
      end
      if (!en && prev_en) begin
        check("R7 strobe width", hi, P);
        if (k == 3 + N) check("R9 done after last char", int'(done), 1);
        else if (k < 3 + N) check("R9 done before last char", int'(done), 0);
      end
      prev_en = en;
    end
  endtask

  initial begin
    void'($urandom(32'h1CD5));
    do_reset();
    watch(3 + N + 3);
    for (int it = 0; it < 6; it++) begin
      do_reset();
      watch(int'($urandom_range(1, 3 + N + 2)));
      repeat ($urandom_range(0, 3 * P)) @(negedge clk);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule